// File: doc/BRIEF.md
# Bidirectional Port with Bus Override

This block is a word-wide general-purpose I/O port made of byte lanes. Each lane has its own output latch and its own direction register, and software reaches all of them through one small write/read register interface. A direction bit of 1 enables the pin driver for that bit. A direction bit of 0 leaves the driver tri-stated. Every pin is sampled through a short synchronizing chain clocked by the system clock. That sampled value is what software reads back, and it is also offered to an external bus controller.

When the bus controller asserts its override, the port hands control of its lanes to that controller. In word mode the controller takes every lane. In byte mode it takes only the low lane. On each lane it takes, the controller supplies the direction, and its alternate data is steered into the same output latch that software normally writes. Software writes to the data latch of a taken lane are dropped. The software direction register keeps its contents, and software may still write it. When the override ends, that register drives the pins again.

Alternate data enters through a valid/ready stream. `alt_ready` is high exactly while the override is on, and a beat is taken on any cycle with both `alt_valid` and `alt_ready` high. The port never stalls an override beat. A beat offered while `alt_ready` is low is dropped, not held, so the controller must offer data only while it owns the port. The synchronized input stream `alt_in` has no handshake and is refreshed on every cycle.

Top module: `bidir_port`

## Requirements
- R1: After reset every output latch bit is 0 and every software direction bit is 0, so `pin_out` and `pin_oe` are all zero.
- R2: A software write with `sw_addr` = {0, lane} loads `sw_wdata` into that lane's output latch, and the value shows on `pin_out` after the next clock edge. Other lanes keep their values.
- R3: A software write with `sw_addr` = {1, lane} loads that lane's direction register. A lane without override drives `pin_oe` from its direction register, where 1 means output.
- R4: Reading with `sw_addr` = {1, lane} returns that lane's software direction register combinationally, with or without override.
- R5: `alt_in` equals `pin_in` delayed by SYNC_STAGES clock edges. Reading with `sw_addr` = {0, lane} returns that lane's byte of the same synchronized value.
- R6: With `ovr_en`=1 and `ovr_word`=1, `pin_oe` equals `ovr_dir`, and a beat with `alt_valid`=1 loads `alt_data` into all output latches at the next edge.
- R7: With `ovr_en`=1 and `ovr_word`=0, only lane 0 is taken over. The upper lanes keep their software direction and latch, and they still accept software writes.
- R8: A software data write to a taken lane is ignored, and that latch keeps its value.
- R9: Software direction writes are accepted during override, and the software direction value becomes active on `pin_oe` as soon as the override ends.
- R10: `alt_ready` is 0 while `ovr_en`=0, and a beat offered then changes no latch.
- R11: A value loaded from the alternate path stays in the latch after the override ends, until software writes that latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sw_we | input | 1 | Software write strobe |
| sw_addr | input | 2 | Register select: {direction-not-data, lane} |
| sw_wdata | input | 8 | Software write byte |
| sw_rdata | output | 8 | Read byte for `sw_addr` |
| ovr_en | input | 1 | Bus controller owns the port |
| ovr_word | input | 1 | 1: all lanes taken, 0: lane 0 only |
| ovr_dir | input | 16 | Controller pin direction, 1 = output |
| alt_valid | input | 1 | Alternate data beat offered |
| alt_ready | output | 1 | Port accepts alternate beats |
| alt_data | input | 16 | Alternate output data (address or data) |
| alt_in | output | 16 | Synchronized pin values for the controller |
| pin_in | input | 16 | Pad input values |
| pin_out | output | 16 | Output latch values to the pads |
| pin_oe | output | 16 | Per-pin driver enable |

## Verification
The bench builds the port with its defaults: BYTE_W=8, NUM_BYTES=2 and SYNC_STAGES=2. Two lanes are the smallest setup that separates byte mode from word mode, so a single run reaches both the lane that is taken over and the lane left to software. A two-stage chain makes the input latency long enough that a missing or extra stage shows up in both `alt_in` and the data read-back.

// File: rtl/bidir_port_pkg.sv
package bidir_port_pkg;
  // Top bit of the software address picks the register kind.
  typedef enum logic {
    REG_DATA = 1'b0,
    REG_DIR  = 1'b1
  } reg_kind_e;
endpackage

// File: rtl/port_in_sync.sv
module port_in_sync #(
  parameter int W      = 16,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[s] <= '0;
        else        chain[s] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[s] <= '0;
        else        chain[s] <= chain[s-1];
      end
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/port_lane.sv
module port_lane #(
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          taken,      // lane owned by the bus controller
  input  logic          alt_take,   // accepted alternate beat
  input  logic [BW-1:0] alt_byte,
  input  logic [BW-1:0] ctl_dir,
  input  logic          wr_data,
  input  logic          wr_dir,
  input  logic [BW-1:0] wdata,
  output logic [BW-1:0] lat_q,
  output logic [BW-1:0] dir_q,
  output logic [BW-1:0] oe
);
  logic [BW-1:0] lat_d;
  logic          lat_load;

  // One latch, two sources: the override mux picks the alternate byte.
  always_comb begin
    if (taken) begin
      lat_load = alt_take;
      lat_d    = alt_byte;
    end else begin
      lat_load = wr_data;
      lat_d    = wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        lat_q <= '0;
    else if (lat_load) lat_q <= lat_d;
  end

  // Software direction is kept through override.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      dir_q <= '0;
    else if (wr_dir) dir_q <= wdata;
  end

  assign oe = taken ? ctl_dir : dir_q;
endmodule

// File: rtl/bidir_port.sv
module bidir_port
  import bidir_port_pkg::*;
#(
  parameter int BYTE_W      = 8,
  parameter int NUM_BYTES   = 2,
  parameter int SYNC_STAGES = 2,
  localparam int PORT_W = BYTE_W * NUM_BYTES,
  localparam int IDX_W  = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1,
  localparam int ADDR_W = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_we,
  input  logic [ADDR_W-1:0] sw_addr,
  input  logic [BYTE_W-1:0] sw_wdata,
  output logic [BYTE_W-1:0] sw_rdata,
  input  logic              ovr_en,
  input  logic              ovr_word,
  input  logic [PORT_W-1:0] ovr_dir,
  input  logic              alt_valid,
  output logic              alt_ready,
  input  logic [PORT_W-1:0] alt_data,
  output logic [PORT_W-1:0] alt_in,
  input  logic [PORT_W-1:0] pin_in,
  output logic [PORT_W-1:0] pin_out,
  output logic [PORT_W-1:0] pin_oe
);
  logic [IDX_W-1:0]  lane_sel;
  reg_kind_e         kind;
  logic              alt_take;
  logic [PORT_W-1:0] sync_q;
  logic [PORT_W-1:0] dir_all;

  assign lane_sel  = sw_addr[IDX_W-1:0];
  assign kind      = reg_kind_e'(sw_addr[ADDR_W-1]);
  assign alt_ready = ovr_en;
  assign alt_take  = alt_valid && alt_ready;

  port_in_sync #(.W(PORT_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_in), .q(sync_q)
  );
  assign alt_in = sync_q;

  for (genvar b = 0; b < NUM_BYTES; b++) begin : g_lane
    logic taken;
    logic hit;
    // Lane 0 goes to the controller in either mode, upper lanes only in word mode.
    if (b == 0) begin : g_low
      assign taken = ovr_en;
    end else begin : g_up
      assign taken = ovr_en && ovr_word;
    end
    assign hit = sw_we && (lane_sel == IDX_W'(b));

    port_lane #(.BW(BYTE_W)) u_lane (
      .clk     (clk),
      .rst_n   (rst_n),
      .taken   (taken),
      .alt_take(alt_take),
      .alt_byte(alt_data[b*BYTE_W +: BYTE_W]),
      .ctl_dir (ovr_dir[b*BYTE_W +: BYTE_W]),
      .wr_data (hit && (kind == REG_DATA)),
      .wr_dir  (hit && (kind == REG_DIR)),
      .wdata   (sw_wdata),
      .lat_q   (pin_out[b*BYTE_W +: BYTE_W]),
      .dir_q   (dir_all[b*BYTE_W +: BYTE_W]),
      .oe      (pin_oe[b*BYTE_W +: BYTE_W])
    );
  end

  always_comb begin
    sw_rdata = '0;
    for (int b = 0; b < NUM_BYTES; b++) begin
      if (lane_sel == IDX_W'(b)) begin
        sw_rdata = (kind == REG_DIR) ? dir_all[b*BYTE_W +: BYTE_W]
                                     : sync_q[b*BYTE_W +: BYTE_W];
      end
    end
  end
endmodule

// File: rtl/bidir_port_checker.sv
module bidir_port_checker #(
  parameter int BYTE_W    = 8,
  parameter int NUM_BYTES = 2,
  parameter int ADDR_W    = 2,
  localparam int PORT_W = BYTE_W * NUM_BYTES
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sw_we,
  input logic [ADDR_W-1:0] sw_addr,
  input logic              ovr_en,
  input logic              ovr_word,
  input logic [PORT_W-1:0] ovr_dir,
  input logic              alt_valid,
  input logic              alt_ready,
  input logic [PORT_W-1:0] alt_data,
  input logic [PORT_W-1:0] pin_out,
  input logic [PORT_W-1:0] pin_oe
);
  p_word_oe_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_en && ovr_word) |-> (pin_oe == ovr_dir));

  p_word_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_en && ovr_word && alt_valid) |=> (pin_out == $past(alt_data)));

  p_upper_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_en && !ovr_word && !sw_we) |=> $stable(pin_out[PORT_W-1:BYTE_W]));

  p_sw_dropped_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_en && ovr_word && !alt_valid) |=> $stable(pin_out));

  p_idle_beat_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!ovr_en && !sw_we) |=> $stable(pin_out));

  p_ready_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !ovr_en |-> !alt_ready);
endmodule

bind bidir_port bidir_port_checker #(
  .BYTE_W(BYTE_W), .NUM_BYTES(NUM_BYTES), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .sw_we(sw_we), .sw_addr(sw_addr),
  .ovr_en(ovr_en), .ovr_word(ovr_word), .ovr_dir(ovr_dir),
  .alt_valid(alt_valid), .alt_ready(alt_ready), .alt_data(alt_data),
  .pin_out(pin_out), .pin_oe(pin_oe)
);

// File: tb/bidir_port_test.sv
module bidir_port_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sw_we = 1'b0;
  logic [1:0]  sw_addr = '0;
  logic [7:0]  sw_wdata = '0;
  logic [7:0]  sw_rdata;
  logic        ovr_en = 1'b0, ovr_word = 1'b0, alt_valid = 1'b0;
  logic [15:0] ovr_dir = '0, alt_data = '0, pin_in = '0;
  logic        alt_ready;
  logic [15:0] alt_in, pin_out, pin_oe;

  bidir_port uut (
    .clk(clk), .rst_n(rst_n), .sw_we(sw_we), .sw_addr(sw_addr),
    .sw_wdata(sw_wdata), .sw_rdata(sw_rdata), .ovr_en(ovr_en),
    .ovr_word(ovr_word), .ovr_dir(ovr_dir), .alt_valid(alt_valid),
    .alt_ready(alt_ready), .alt_data(alt_data), .alt_in(alt_in),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  always #2.5 clk = ~clk;

  typedef struct {
    int          cyc;
    string       tag;
    logic [15:0] out, oe, ain;
    logic [7:0]  rd;
    logic        rdy;
  } exp_t;

  exp_t q[$];
  int   cyc = 0;
  int   n_chk = 0, n_fail = 0;
  bit   done = 0;

  // Bench model state, written from the requirements.
  logic [7:0]  m_lat [2];
  logic [7:0]  m_dir [2];
  logic [15:0] m_s1 = '0, m_s2 = '0;

  always @(posedge clk) cyc <= cyc + 1;

  // Monitor: pops expectations that fall due and compares.
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].cyc == cyc) begin
      exp_t e;
      e = q.pop_front();
      n_chk++;
      if (pin_out !== e.out || pin_oe !== e.oe || alt_in !== e.ain ||
          sw_rdata !== e.rd || alt_ready !== e.rdy) begin
        n_fail++;
        $display("FAIL %s: out=%h oe=%h ain=%h rd=%h rdy=%b expected out=%h oe=%h ain=%h rd=%h rdy=%b",
                 e.tag, pin_out, pin_oe, alt_in, sw_rdata, alt_ready,
                 e.out, e.oe, e.ain, e.rd, e.rdy);
      end
    end
  end

  // Driver: applies one cycle of stimulus, advances the model, queues the result.
  task automatic step(input string tag, input logic we, input logic [1:0] a,
                      input logic [7:0] wd, input logic ov, input logic wd_mode,
                      input logic [15:0] od, input logic av, input logic [15:0] ad,
                      input logic [15:0] pin);
    exp_t e;
    logic [15:0] oe_x;
    @(negedge clk); #1;
    sw_we = we; sw_addr = a; sw_wdata = wd; ovr_en = ov; ovr_word = wd_mode;
    ovr_dir = od; alt_valid = av; alt_data = ad; pin_in = pin;
    for (int b = 0; b < 2; b++) begin
      logic tk;
      tk = ov && (b == 0 || wd_mode);
      if (tk) begin
        if (av) m_lat[b] = ad[b*8 +: 8];
      end else if (we && a == {1'b0, b[0]}) m_lat[b] = wd;
      if (we && a == {1'b1, b[0]}) m_dir[b] = wd;
      oe_x[b*8 +: 8] = tk ? od[b*8 +: 8] : m_dir[b];
    end
    m_s2 = m_s1; m_s1 = pin;
    e.cyc = cyc + 1; e.tag = tag;
    e.out = {m_lat[1], m_lat[0]}; e.oe = oe_x; e.ain = m_s2; e.rdy = ov;
    e.rd  = a[1] ? m_dir[a[0]] : m_s2[a[0]*8 +: 8];
    q.push_back(e);
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    m_lat[0] = '0; m_lat[1] = '0; m_dir[0] = '0; m_dir[1] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    step("R1 reset", 0, 2'd2, 8'h00, 0, 0, '0, 0, '0, '0);
    step("R1 reset hi", 0, 2'd3, 8'h00, 0, 0, '0, 0, '0, '0);
    // R2: lane data writes
    step("R2 data lo", 1, 2'd0, 8'hA5, 0, 0, '0, 0, '0, '0);
    step("R2 data hi", 1, 2'd1, 8'h3C, 0, 0, '0, 0, '0, '0);
    // R3: direction writes
    step("R3 dir lo", 1, 2'd2, 8'hF0, 0, 0, '0, 0, '0, '0);
    step("R3 dir hi", 1, 2'd3, 8'h0F, 0, 0, '0, 0, '0, '0);
    // R4: direction read-back
    step("R4 rd dir lo", 0, 2'd2, 8'h00, 0, 0, '0, 0, '0, '0);
    step("R4 rd dir hi", 0, 2'd3, 8'h00, 0, 0, '0, 0, '0, '0);
    // R5: synchronized input path, two patterns
    step("R5 pin a", 0, 2'd0, 8'h00, 0, 0, '0, 0, '0, 16'h1234);
    step("R5 pin b", 0, 2'd1, 8'h00, 0, 0, '0, 0, '0, 16'hC3E1);
    step("R5 pin c", 0, 2'd0, 8'h00, 0, 0, '0, 0, '0, 16'hC3E1);
    step("R5 pin d", 0, 2'd1, 8'h00, 0, 0, '0, 0, '0, 16'hC3E1);
    // R10: beat without override is dropped
    step("R10 beat off", 0, 2'd0, 8'h00, 0, 0, 16'hFFFF, 1, 16'hDEAD, 16'hC3E1);
    // R6: word override load and direction
    step("R6 word load", 0, 2'd0, 8'h00, 1, 1, 16'hFF00, 1, 16'hBEEF, 16'hC3E1);
    // R8: software data write to taken lane
    step("R8 sw drop", 1, 2'd0, 8'h11, 1, 1, 16'h0FF0, 0, 16'h0000, 16'hC3E1);
    // R9 and R4: direction write during override, read back
    step("R9 dir in ovr", 1, 2'd2, 8'h55, 1, 1, 16'h0FF0, 0, 16'h0000, 16'hC3E1);
    step("R4 rd in ovr", 0, 2'd2, 8'h00, 1, 1, 16'h0FF0, 0, 16'h0000, 16'hC3E1);
    // R9 and R11: release override
    step("R9 R11 release", 0, 2'd3, 8'h00, 0, 0, '0, 0, '0, 16'hC3E1);
    // R7: byte mode, upper lane stays with software
    step("R7 byte load", 0, 2'd0, 8'h00, 1, 0, 16'hFFAA, 1, 16'h7788, 16'h0000);
    step("R7 hi write", 1, 2'd1, 8'h99, 1, 0, 16'hFFAA, 0, 16'h0000, 16'h0000);
    step("R8 lo drop", 1, 2'd0, 8'h22, 1, 0, 16'hFFAA, 0, 16'h0000, 16'h0000);
    step("R7 hi dir", 1, 2'd3, 8'hC0, 1, 0, 16'h00AA, 0, 16'h0000, 16'h0000);
    // R11: software regains the low latch after release
    step("R11 sw back", 1, 2'd0, 8'h66, 0, 0, '0, 0, '0, 16'h0000);
    step("R5 settle", 0, 2'd0, 8'h00, 0, 0, '0, 0, '0, 16'h0000);
    repeat (3) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule